// File: doc/BRIEF.md
# Two-Master Cascaded Interrupt Aggregator

This block gathers 112 single-bit interrupt sources into fourteen groups of eight and raises one interrupt line toward a host processor. The groups are split evenly between two masters, seven groups each. Each source has a pending latch that is set on a rising edge of the source while the source is enabled. Each group has its own directly addressed registers: a masked status view, a write-one-to-clear port, a mask and a live level view. No group-select register is needed.

The host reaches the block over a simple register bus with a 10-bit address and 8-bit data. A write takes effect at the clock edge on which `wr_en` is sampled. A read is sampled with `rd_en`, and `rdata` is returned one cycle later with `rvalid`. Each master has a summary register whose bits 7:1 point to its groups. Master 0's summary bit 0 is a cascade flag: it tells the host to read master 1's summary as well. A small bus state machine has two states. `BUS_IDLE` moves to `BUS_RESP` when a read is sampled. `BUS_RESP` goes back to `BUS_IDLE` when no read is sampled, and stays in `BUS_RESP` when another read is sampled.

Top module: `irqc_two_master`

## Requirements
- R1: After reset every mask bit is 1, every pending latch is 0, `irq_out` is 0 and `rvalid` is 0. Reading any mask register returns 0xFF.
- R2: The base of master 0 is 0x130 and the base of master 1 is 0x1B0. For group b (1..7) of a master, the registers sit at fixed offsets from that base:
  - base+0: summary.
  - base+b: status (read).
  - base+b+1: clear (write).
  - base+b+8: mask.
  - base+b+15: live level.
  A read at base+8 returns 0, and so does a read of any address outside both windows.
- R3: A 0-to-1 change on an enabled source (mask bit 0) sets its pending latch at the next clock edge. The latch stays set after the source falls.
- R4: A rising edge on a source whose mask bit is 1 does not set its latch. A status read returns pending AND NOT mask, so masking a latched source hides it and unmasking shows it again.
- R5: Writing a byte to a clear address clears the latches for the 1-bits of that byte and leaves the others untouched. If a new edge arrives in the same cycle as its clear, the latch stays set.
- R6: A read of a live-level register returns the present raw levels of that group's eight sources, whether or not they are masked.
- R7: In each master summary, bit b (1..7) is 1 exactly when group b of that master has a nonzero status. Bit 0 of master 1's summary always reads 0.
- R8: Bit 0 of master 0's summary is 1 exactly when any group of master 1 has a nonzero status.
- R9: `irq_out` is 1 exactly when master 0's summary is nonzero. This is the same as saying some unmasked source is pending anywhere in the block.
- R10: Source n sits at bit n mod 8 of global group g = n div 8. Its master is g div 7, and its group inside that master is b = (g mod 7) + 1.
- R11: `rdata` and `rvalid` follow a sampled `rd_en` by one clock cycle. When no read is sampled, `rdata` holds its value and `rvalid` is 0 in the next cycle.
- R12: A mask register reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src | input | 112 | Raw interrupt source levels, bit n is source n |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 10 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read data valid, one cycle after `rd_en` |
| irq_out | output | 1 | Aggregated interrupt to the host |

## Verification
The hardest case to reach is the cycle in which a fresh source edge and a clear write for the same bit land on the same clock edge. The stimulus drives the source high and the clear strobe together on one falling edge, so both are sampled at the next rising edge. It then reads status to confirm the latch survived. The cascade path is also exercised at both ends of the source range: master 1 sources are raised one at a time, and both summaries are read to show that master 0's bit 0 is set while master 1's bit 0 stays clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Register offsets relative to a master base; group index b is added to each
    localparam int OFS_SUMMARY = 0;
    localparam int OFS_STATUS  = 0;
    localparam int OFS_CLEAR   = 1;
    localparam int OFS_MASK    = 8;
    localparam int OFS_LEVEL   = 15;
    localparam int WINDOW_SPAN = 23;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_t;

endpackage

// File: rtl/irqc_src_group.sv
module irqc_src_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         clr_we,
    input  logic         mask_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] level_o
);

    logic [W-1:0] prev_q;
    logic [W-1:0] pend_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] rise;
    logic [W-1:0] clr_bits;
    logic [W-1:0] pend_d;

    always_comb begin
        rise     = src & ~prev_q;
        clr_bits = clr_we ? wdata : '0;
        // a new edge wins over a clear in the same cycle
        pend_d   = (pend_q & ~clr_bits) | (rise & ~mask_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
            mask_q <= '1;
        end else begin
            prev_q <= src;
            pend_q <= pend_d;
            if (mask_we) begin
                mask_q <= wdata;
            end
        end
    end

    assign status_o = pend_q & ~mask_q;
    assign mask_o   = mask_q;
    assign level_o  = src;

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise & ~mask_q) != '0) |=> ((pend_q & $past(rise & ~mask_q)) == $past(rise & ~mask_q))); // R3

    AST_MASKED_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_q & ~pend_q) != '0) |=> ((pend_q & $past(mask_q & ~pend_q)) == '0)); // R4

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((pend_q & $past(wdata & ~rise)) == '0)); // R5

endmodule

// File: rtl/irqc_master_sum.sv
module irqc_master_sum #(
    parameter int W   = 8,
    parameter int BPM = 7
) (
    input  logic [W-1:0] grp_status [BPM],
    input  logic         cascade_in,
    output logic [W-1:0] summary
);

    assign summary[0] = cascade_in;

    for (genvar b = 1; b <= BPM; b++) begin : g_bit
        assign summary[b] = |grp_status[b-1];
    end

    if (W > BPM + 1) begin : g_pad
        assign summary[W-1:BPM+1] = '0;
    end

endmodule

// File: rtl/irqc_regbus.sv
module irqc_regbus
    import irqc_pkg::*;
#(
    parameter int             AW    = 10,
    parameter int             W     = 8,
    parameter int             NM    = 2,
    parameter int             BPM   = 7,
    parameter logic [AW-1:0]  BASE0 = 10'h130,
    parameter logic [AW-1:0]  BASE1 = 10'h1B0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  sums       [NM],
    input  logic [W-1:0]  grp_status [NM][BPM],
    input  logic [W-1:0]  grp_mask   [NM][BPM],
    input  logic [W-1:0]  grp_level  [NM][BPM],
    output logic [W-1:0]  rdata,
    output logic          rvalid
);

    bus_state_t   state_q, state_d;
    logic [W-1:0] rd_mux;
    logic [W-1:0] rdata_q;

    // read decode over both windows
    always_comb begin
        logic [AW-1:0] base_v;
        logic [AW-1:0] off_v;
        rd_mux = '0;
        for (int m = 0; m < NM; m++) begin
            base_v = (m == 0) ? BASE0 : BASE1;
            off_v  = addr - base_v;
            if (addr >= base_v && off_v < AW'(WINDOW_SPAN)) begin
                if (off_v == AW'(OFS_SUMMARY)) begin
                    rd_mux = sums[m];
                end
                for (int b = 1; b <= BPM; b++) begin
                    if (off_v == AW'(b + OFS_STATUS)) rd_mux = grp_status[m][b-1];
                    if (off_v == AW'(b + OFS_MASK))   rd_mux = grp_mask[m][b-1];
                    if (off_v == AW'(b + OFS_LEVEL))  rd_mux = grp_level[m][b-1];
                end
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_en)  state_d = BUS_RESP;
            BUS_RESP: if (!rd_en) state_d = BUS_IDLE;
            default:              state_d = BUS_IDLE;
        endcase
    end

    // state register and read data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en) begin
                rdata_q <= rd_mux;
            end
        end
    end

    // outputs
    always_comb begin
        rdata = rdata_q;
        unique case (state_q)
            BUS_IDLE: rvalid = 1'b0;
            BUS_RESP: rvalid = 1'b1;
            default:  rvalid = 1'b0;
        endcase
    end

    AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid); // R11

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rvalid && $stable(rdata))); // R11

endmodule

// File: rtl/irqc_two_master.sv
module irqc_two_master
    import irqc_pkg::*;
#(
    parameter int             W     = 8,
    parameter int             BPM   = 7,
    parameter int             AW    = 10,
    parameter logic [AW-1:0]  BASE0 = 10'h130,
    parameter logic [AW-1:0]  BASE1 = 10'h1B0,
    localparam int            NM    = 2,
    localparam int            NSRC  = NM * BPM * W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [AW-1:0]   addr,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    rdata,
    output logic            rvalid,
    output logic            irq_out
);

    logic [W-1:0] grp_status [NM][BPM];
    logic [W-1:0] grp_mask   [NM][BPM];
    logic [W-1:0] grp_level  [NM][BPM];
    logic [W-1:0] sums       [NM];
    logic         cascade    [NM];

    for (genvar m = 0; m < NM; m++) begin : g_master
        localparam logic [AW-1:0] BASE = (m == 0) ? BASE0 : BASE1;
        for (genvar b = 1; b <= BPM; b++) begin : g_grp
            localparam int            G      = m * BPM + b - 1;
            localparam logic [AW-1:0] CLR_A  = BASE + AW'(b + OFS_CLEAR);
            localparam logic [AW-1:0] MASK_A = BASE + AW'(b + OFS_MASK);
            logic clr_we, mask_we;
            assign clr_we  = wr_en && (addr == CLR_A);
            assign mask_we = wr_en && (addr == MASK_A);
            irqc_src_group #(.W(W)) u_grp (
                .clk      (clk),
                .rst_n    (rst_n),
                .src      (src[G*W +: W]),
                .clr_we   (clr_we),
                .mask_we  (mask_we),
                .wdata    (wdata),
                .status_o (grp_status[m][b-1]),
                .mask_o   (grp_mask[m][b-1]),
                .level_o  (grp_level[m][b-1])
            );
        end
        irqc_master_sum #(.W(W), .BPM(BPM)) u_sum (
            .grp_status (grp_status[m]),
            .cascade_in (cascade[m]),
            .summary    (sums[m])
        );
    end

    // master 1 feeds master 0 bit 0; the last master has nothing below it
    assign cascade[0] = |sums[1][W-1:1];
    assign cascade[1] = 1'b0;
    assign irq_out    = |sums[0];

    irqc_regbus #(
        .AW(AW), .W(W), .NM(NM), .BPM(BPM), .BASE0(BASE0), .BASE1(BASE1)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .addr       (addr),
        .sums       (sums),
        .grp_status (grp_status),
        .grp_mask   (grp_mask),
        .grp_level  (grp_level),
        .rdata      (rdata),
        .rvalid     (rvalid)
    );

    logic any_m1;
    logic any_all;
    always_comb begin
        any_m1  = 1'b0;
        any_all = 1'b0;
        for (int m = 0; m < NM; m++) begin
            for (int b = 0; b < BPM; b++) begin
                any_all = any_all | (|grp_status[m][b]);
                if (m == 1) any_m1 = any_m1 | (|grp_status[m][b]);
            end
        end
    end

    AST_IRQ_TRACKS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == any_all); // R9

    AST_CASCADE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        sums[0][0] == any_m1); // R8

    AST_LAST_NO_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
        sums[1][0] == 1'b0); // R7

endmodule

// File: tb/sim_irqc_two_master.sv
`timescale 1ns/1ps
module sim_irqc_two_master;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [111:0] src = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [9:0]   addr = '0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rdata;
    logic         rvalid;
    logic         irq_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irqc_two_master u0 (
        .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .irq_out(irq_out)
    );

    // source index, status address, bit value, own summary address, own summary, master 0 summary
    localparam int NVEC = 6;
    localparam int VN   [NVEC] = '{0,     13,    55,    56,    70,    111};
    localparam int VST  [NVEC] = '{'h131, 'h132, 'h137, 'h1B1, 'h1B2, 'h1B7};
    localparam int VBIT [NVEC] = '{'h01,  'h20,  'h80,  'h01,  'h40,  'h80};
    localparam int VSA  [NVEC] = '{'h130, 'h130, 'h130, 'h1B0, 'h1B0, 'h1B0};
    localparam int VSV  [NVEC] = '{'h02,  'h04,  'h80,  'h02,  'h04,  'h80};
    localparam int VM0  [NVEC] = '{'h02,  'h04,  'h80,  'h01,  'h01,  'h01};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 10'(a); wdata = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        rd_en = 1'b1; addr = 10'(a);
        @(negedge clk);
        rd_en = 1'b0;
        d = int'(rdata);
        if (!rvalid) begin
            checks++; errors++;
            $display("FAIL R11: rvalid actual 0 expected 1");
        end
    endtask

    task automatic pulse(input int n);
        @(negedge clk);
        src[n] = 1'b1;
        @(negedge clk);
        src[n] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        int held;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 irq_out in reset", int'(irq_out), 0);
        chk("R1 rvalid in reset", int'(rvalid), 0);
        rst_n = 1'b1;
        rd('h139, v); chk("R1 mask m0 b1", v, 'hFF);
        rd('h1BF, v); chk("R1 mask m1 b7", v, 'hFF);
        rd('h130, v); chk("R1 summary m0", v, 0);

        // R11: rdata held, rvalid low when idle
        held = v;
        @(negedge clk);
        chk("R11 rvalid idle", int'(rvalid), 0);
        chk("R11 rdata held", int'(rdata), held);

        // table: R3 R7 R8 R9 R10 R2 R5
        for (int i = 0; i < NVEC; i++) begin
            wr(VST[i] + 8, ~VBIT[i] & 'hFF);
            pulse(VN[i]);
            rd(VST[i], v);   chk("R3/R10 status after edge", v, VBIT[i]);
            rd(VSA[i], v);   chk("R7 own summary", v, VSV[i]);
            rd('h130, v);    chk("R8 master 0 summary", v, VM0[i]);
            chk("R9 irq raised", int'(irq_out), 1);
            wr(VST[i] + 1, VBIT[i]);
            rd(VST[i], v);   chk("R5 status after clear", v, 0);
            chk("R9 irq dropped", int'(irq_out), 0);
            wr(VST[i] + 8, 'hFF);
        end

        // R12: mask readback
        wr('h13A, 'h5A);
        rd('h13A, v); chk("R12 mask readback", v, 'h5A);
        wr('h13A, 'hFF);

        // R4: masked edge does not latch; masking hides a latched bit
        pulse(0);
        wr('h139, 'hFE);
        rd('h131, v); chk("R4 masked edge ignored", v, 0);
        chk("R4 irq stays low", int'(irq_out), 0);
        pulse(0);
        wr('h139, 'hFF);
        rd('h131, v); chk("R4 masked view hidden", v, 0);
        chk("R4 irq hidden", int'(irq_out), 0);
        wr('h139, 'hFE);
        rd('h131, v); chk("R4 unmask shows latch", v, 'h01);
        wr('h132, 'h01);

        // R5: partial clear and edge-versus-clear in the same cycle
        wr('h139, 'h00);
        pulse(1);
        pulse(2);
        rd('h131, v); chk("R5 two latched", v, 'h06);
        wr('h132, 'h02);
        rd('h131, v); chk("R5 partial clear", v, 'h04);
        @(negedge clk);
        src[1] = 1'b1; wr_en = 1'b1; addr = 10'h132; wdata = 8'h02;
        @(negedge clk);
        src[1] = 1'b0; wr_en = 1'b0;
        rd('h131, v); chk("R5 edge wins over clear", v, 'h06);
        wr('h132, 'hFF);
        wr('h139, 'hFF);

        // R6: live level
        @(negedge clk);
        src[57] = 1'b1; src[3] = 1'b1;
        rd('h1C0, v); chk("R6 level m1 b1", v, 'h02);
        rd('h140, v); chk("R6 level m0 b1", v, 'h08);
        @(negedge clk);
        src[57] = 1'b0; src[3] = 1'b0;
        rd('h1C0, v); chk("R6 level cleared", v, 0);

        // R2: zero-reading addresses
        rd('h138, v); chk("R2 base+8 reads zero", v, 0);
        rd('h100, v); chk("R2 unmapped reads zero", v, 0);
        rd('h1B0, v); chk("R7 master 1 summary idle", v, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule